// File: doc/BRIEF.md
# Ping-pong bitmap display scanner

This block colours the pixels of a 256x256 window on a raster display. Each pixel is one bit of a packed board image. The board is held in two memories: one holds the generation on show and the other receives the next generation. A buffer-select output (`buf_sel`) tells the memory wrapper which of the two to route to the read port. An external sync generator supplies pixel coordinates with a pixel-enable strobe. The block turns each coordinate into a word fetch and a bit select. It drives a 24-bit colour one clock after the strobe.

The block also paces the simulation. A small state machine counts `gen_tick` pulses in state COUNT. When `TICKS_PER_GEN` ticks have arrived, the tick-count transition takes it to ARMED. When the bottom-right pixel of the window is next shown, the frame-end transition takes it to UPDATE and pulses `upd_start`. The updater then computes the next generation. When the updater answers with `upd_done`, the done transition returns the machine to COUNT, and the buffer select flips so the new generation goes on show. With a tick period of 1 ms and `TICKS_PER_GEN` = 1000, generations advance about once per second, whatever the frame rate.

Top module: `pingpong_scan`

## Requirements
- R1: While reset is held and just after it, `pix_rgb` is 0x000000, `buf_sel` is 0, `upd_start` is 0 and `rd_en` is 0.
- R2: `rd_en` is high in the same cycle as `pix_en` only when the strobe's x is one left of the first pixel of a word inside the window, on a window row. In that cycle `rd_addr` is the local row in bits 10:3 and the word index (0 to 7) in bits 2:0. The first word of a row is fetched at x = WIN_X-1. No fetch is made at x = WIN_X+255.
- R3: Local pixel column 32*w+k shows bit k of word w, so bit 0 is the leftmost of its 32 pixels. Read data arrives one cycle after `rd_en`. The colour of a strobed pixel appears on `pix_rgb` one clock after its strobe.
- R4: A set bit is shown as white (0xFFFFFF) and a clear bit as blue (0x0000FF).
- R5: A strobed pixel outside the window (x < WIN_X, x >= WIN_X+256, or the same bounds on y) is shown as black (0x000000).
- R6: In cycles without `pix_en`, `pix_rgb` keeps its value.
- R7: `buf_sel` flips only on a cycle where `upd_done` is high in state UPDATE. A done pulse in COUNT or ARMED is ignored. Read data is taken from the memory that `buf_sel` names.
- R8: `upd_start` is a single-cycle pulse. It appears the clock after the strobe of pixel (WIN_X+255, WIN_Y+255) while in ARMED, and the machine then enters UPDATE.
- R9: In COUNT, the `TICKS_PER_GEN`-th tick since reset or since the last swap moves the machine to ARMED. Ticks seen in ARMED or UPDATE are not counted.
- R10: A bottom-right pixel shown while in COUNT or UPDATE produces no `upd_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel strobe; pix_x/pix_y are valid |
| pix_x | input | COORD_W | Screen column of the strobed pixel |
| pix_y | input | COORD_W | Screen row of the strobed pixel |
| rd_en | output | 1 | Word read request to the selected board memory |
| rd_addr | output | 11 | Word address {row, word index} |
| rd_data | input | 32 | Word returned one cycle after rd_en |
| buf_sel | output | 1 | Which memory holds the shown generation |
| pix_rgb | output | 24 | Pixel colour, registered |
| gen_tick | input | 1 | Pacing tick pulse |
| upd_start | output | 1 | Pulse: compute the next generation |
| upd_done | input | 1 | Pulse: next generation written |

## Verification
A stuck or skipped state in the pacing machine shows at the ports within one frame. In that case `upd_start` is missing or extra at the bottom-right pixel, or `buf_sel` fails to flip on the first done pulse after it. A tick counter that is off by one shifts the start by a whole frame, so the bench sends ticks in exact numbers and checks the start pulse after each frame end. A wrong prefetch position or bit order corrupts `pix_rgb` on the next strobe: the bench compares every pixel of whole rows against random board contents. Wrong buffer routing shows on the first row fetched after a swap.

// File: rtl/pps_pkg.sv
package pps_pkg;
    typedef enum logic [1:0] {
        GS_COUNT  = 2'd0,
        GS_ARMED  = 2'd1,
        GS_UPDATE = 2'd2
    } gen_state_t;

    localparam int          RGB_W     = 24;
    localparam logic [23:0] RGB_ALIVE = 24'hFF_FF_FF;
    localparam logic [23:0] RGB_DEAD  = 24'h00_00_FF;
    localparam logic [23:0] RGB_OFF   = 24'h00_00_00;
endpackage

// File: rtl/scan_decode.sv
module scan_decode #(
    parameter int COORD_W = 10,
    parameter int WIN_X   = 64,
    parameter int WIN_Y   = 32,
    parameter int SIDE    = 256,
    parameter int ROW_W   = 8,
    parameter int COL_W   = 3,
    parameter int BIT_W   = 5,
    parameter int ADDR_W  = 11
) (
    input  logic               pix_en,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    output logic               in_win,
    output logic [BIT_W-1:0]   bit_idx,
    output logic               fetch,
    output logic [ADDR_W-1:0]  fetch_addr,
    output logic               last_pix
);
    logic signed [31:0] lx;
    logic signed [31:0] nx;
    logic signed [31:0] ly;
    logic               in_row;

    assign lx = $signed(32'(pix_x)) - WIN_X;
    assign nx = lx + 1;
    assign ly = $signed(32'(pix_y)) - WIN_Y;

    assign in_row  = (ly >= 0) && (ly < SIDE);
    assign in_win  = in_row && (lx >= 0) && (lx < SIDE);
    assign bit_idx = lx[BIT_W-1:0];

    // prefetch: strobe one column ahead of a word's first pixel
    assign fetch      = pix_en && in_row && (nx >= 0) && (nx < SIDE)
                        && (nx[BIT_W-1:0] == '0);
    assign fetch_addr = {ly[ROW_W-1:0], nx[BIT_W+COL_W-1:BIT_W]};
    assign last_pix   = pix_en && (lx == SIDE - 1) && (ly == SIDE - 1);
endmodule

// File: rtl/pix_color.sv
module pix_color
    import pps_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BIT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              in_win,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              fetch,
    input  logic [WORD_W-1:0] rd_data,
    output logic [RGB_W-1:0]  pix_rgb
);
    logic              data_vld_q;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] cur_word;

    // read data is live the cycle after the fetch; hold it afterwards
    assign cur_word = data_vld_q ? rd_data : word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_vld_q <= 1'b0;
            word_q     <= '0;
            pix_rgb    <= RGB_OFF;
        end else begin
            data_vld_q <= fetch;
            if (data_vld_q)
                word_q <= rd_data;
            if (pix_en) begin
                if (!in_win)
                    pix_rgb <= RGB_OFF;
                else if (cur_word[bit_idx])
                    pix_rgb <= RGB_ALIVE;
                else
                    pix_rgb <= RGB_DEAD;
            end
        end
    end
endmodule

// File: rtl/gen_ctrl.sv
module gen_ctrl
    import pps_pkg::*;
#(
    parameter int TICKS_PER_GEN = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gen_tick,
    input  logic last_pix,
    input  logic upd_done,
    output logic upd_start,
    output logic buf_sel
);
    localparam int CNT_W = $clog2(TICKS_PER_GEN + 1);

    gen_state_t       state_q;
    gen_state_t       state_d;
    logic [CNT_W-1:0] tick_cnt;
    logic             tick_hit;

    assign tick_hit = gen_tick && (tick_cnt == CNT_W'(TICKS_PER_GEN - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= GS_COUNT;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_COUNT:  if (tick_hit) state_d = GS_ARMED;
            GS_ARMED:  if (last_pix) state_d = GS_UPDATE;
            GS_UPDATE: if (upd_done) state_d = GS_COUNT;
            default:   state_d = GS_COUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_start <= 1'b0;
            buf_sel   <= 1'b0;
            tick_cnt  <= '0;
        end else begin
            upd_start <= (state_q == GS_ARMED) && last_pix;
            if ((state_q == GS_UPDATE) && upd_done)
                buf_sel <= ~buf_sel;
            if (state_q != GS_COUNT)
                tick_cnt <= '0;
            else if (gen_tick)
                tick_cnt <= tick_hit ? '0 : tick_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pingpong_scan.sv
module pingpong_scan
    import pps_pkg::*;
#(
    parameter int COORD_W       = 10,
    parameter int WIN_X         = 64,
    parameter int WIN_Y         = 32,
    parameter int SIDE          = 256,
    parameter int WORD_W        = 32,
    parameter int TICKS_PER_GEN = 1000,
    localparam int WPR          = SIDE / WORD_W,
    localparam int ROW_W        = $clog2(SIDE),
    localparam int COL_W        = $clog2(WPR),
    localparam int BIT_W        = $clog2(WORD_W),
    localparam int ADDR_W       = ROW_W + COL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_en,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic [WORD_W-1:0]  rd_data,
    output logic               buf_sel,
    output logic [RGB_W-1:0]   pix_rgb,
    input  logic               gen_tick,
    output logic               upd_start,
    input  logic               upd_done
);
    logic             in_win;
    logic [BIT_W-1:0] bit_idx;
    logic             fetch;
    logic             last_pix;

    scan_decode #(
        .COORD_W(COORD_W), .WIN_X(WIN_X), .WIN_Y(WIN_Y), .SIDE(SIDE),
        .ROW_W(ROW_W), .COL_W(COL_W), .BIT_W(BIT_W), .ADDR_W(ADDR_W)
    ) u_decode (
        .pix_en(pix_en), .pix_x(pix_x), .pix_y(pix_y),
        .in_win(in_win), .bit_idx(bit_idx), .fetch(fetch),
        .fetch_addr(rd_addr), .last_pix(last_pix)
    );

    assign rd_en = fetch;

    pix_color #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_color (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .in_win(in_win),
        .bit_idx(bit_idx), .fetch(fetch), .rd_data(rd_data), .pix_rgb(pix_rgb)
    );

    gen_ctrl #(.TICKS_PER_GEN(TICKS_PER_GEN)) u_gen (
        .clk(clk), .rst_n(rst_n), .gen_tick(gen_tick), .last_pix(last_pix),
        .upd_done(upd_done), .upd_start(upd_start), .buf_sel(buf_sel)
    );
endmodule

// File: rtl/pingpong_scan_chk.sv
module pingpong_scan_chk
    import pps_pkg::*;
#(
    parameter int COORD_W = 10,
    parameter int WIN_X   = 64,
    parameter int WIN_Y   = 32,
    parameter int SIDE    = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pix_en,
    input logic [COORD_W-1:0] pix_x,
    input logic [COORD_W-1:0] pix_y,
    input logic               rd_en,
    input logic               buf_sel,
    input logic [RGB_W-1:0]   pix_rgb,
    input logic               upd_start,
    input logic               upd_done
);
    logic inside_c;
    logic corner_c;

    assign inside_c = (int'(pix_x) >= WIN_X) && (int'(pix_x) < WIN_X + SIDE)
                   && (int'(pix_y) >= WIN_Y) && (int'(pix_y) < WIN_Y + SIDE);
    assign corner_c = (int'(pix_x) == WIN_X + SIDE - 1)
                   && (int'(pix_y) == WIN_Y + SIDE - 1);

    // R2
    fetch_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> pix_en);

    // R4
    colour_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_rgb == RGB_ALIVE) || (pix_rgb == RGB_DEAD) || (pix_rgb == RGB_OFF));

    // R5
    outside_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !inside_c) |=> (pix_rgb == RGB_OFF));

    // R6
    colour_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(pix_rgb));

    // R7
    swap_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_done |=> $stable(buf_sel));

    // R8
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_start |=> !upd_start);

    // R8
    start_after_corner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_start |-> $past(pix_en && corner_c));
endmodule

bind pingpong_scan pingpong_scan_chk #(
    .COORD_W(COORD_W), .WIN_X(WIN_X), .WIN_Y(WIN_Y), .SIDE(SIDE)
) u_chk (.*);

// File: tb/pingpong_scan_bench.sv
`timescale 1ns/1ps
module pingpong_scan_bench;
    localparam int WX = 64;
    localparam int WY = 32;
    localparam int TK = 3;
    localparam logic [23:0] WHITE = 24'hFFFFFF;
    localparam logic [23:0] BLUE  = 24'h0000FF;
    localparam logic [23:0] BLACK = 24'h000000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b0;
    logic [9:0]  pix_x = '0;
    logic [9:0]  pix_y = '0;
    logic        rd_en;
    logic [10:0] rd_addr;
    logic [31:0] rd_data = '0;
    logic        buf_sel;
    logic [23:0] pix_rgb;
    logic        gen_tick = 1'b0;
    logic        upd_start;
    logic        upd_done = 1'b0;

    always #2.5 clk = ~clk;

    pingpong_scan #(.WIN_X(WX), .WIN_Y(WY), .TICKS_PER_GEN(TK)) u_pingpong_scan (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pix_x(pix_x), .pix_y(pix_y),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .buf_sel(buf_sel),
        .pix_rgb(pix_rgb), .gen_tick(gen_tick), .upd_start(upd_start),
        .upd_done(upd_done)
    );

    logic [31:0] mem0 [2048];
    logic [31:0] mem1 [2048];

    always_ff @(posedge clk)
        if (rd_en) rd_data <= buf_sel ? mem1[rd_addr] : mem0[rd_addr];

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          finished = 0;
    int          m_state = 0;
    int          m_cnt = 0;
    bit          m_sel = 0;
    logic [31:0] ew = '0;
    logic [23:0] exp_rgb = BLACK;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] colour_of(input logic [31:0] w, input int lx);
        return w[lx % 32] ? WHITE : BLUE;
    endfunction

    // one clock: drive at negedge, check at the following negedge
    task automatic step(input bit en, input int x, input int y, input bit tk, input bit dn);
        int lx, ly, nx, addr;
        bit f, exp_start;
        pix_en = en; pix_x = 10'(x); pix_y = 10'(y); gen_tick = tk; upd_done = dn;
        #1;
        lx = x - WX; ly = y - WY; nx = lx + 1;
        f = en && ly >= 0 && ly < 256 && nx >= 0 && nx < 256 && (nx % 32 == 0);
        check(rd_en == f, "R2 rd_en", 32'(rd_en), 32'(f));
        if (en) begin
            if (ly >= 0 && ly < 256 && lx >= 0 && lx < 256)
                exp_rgb = colour_of(ew, lx);       // R3 R4
            else
                exp_rgb = BLACK;                   // R5
        end
        if (f) begin
            addr = ly * 8 + nx / 32;
            check(int'(rd_addr) == addr, "R2 rd_addr", 32'(rd_addr), 32'(addr));
            ew = m_sel ? mem1[addr] : mem0[addr];
        end
        exp_start = 0;
        case (m_state)
            0: if (tk) begin
                   if (m_cnt == TK - 1) begin m_state = 1; m_cnt = 0; end
                   else m_cnt++;
               end
            1: if (en && x == WX + 255 && y == WY + 255) begin
                   exp_start = 1; m_state = 2;
               end
            default: if (dn) begin m_sel = ~m_sel; m_state = 0; m_cnt = 0; end
        endcase
        @(negedge clk);
        check(pix_rgb == exp_rgb, "R3 R4 R5 R6 pix_rgb", 32'(pix_rgb), 32'(exp_rgb));
        check(upd_start == exp_start, "R8 R9 R10 upd_start", 32'(upd_start), 32'(exp_start));
        check(buf_sel == m_sel, "R7 buf_sel", 32'(buf_sel), 32'(m_sel));
    endtask

    task automatic scan_row(input int y, input bit gaps, input bit noise);
        for (int x = WX - 1; x <= WX + 256; x++) begin
            if (gaps && ($urandom % 5 == 0))
                step(0, $urandom % 1024, $urandom % 1024,
                     noise && ($urandom % 20 == 0), noise && ($urandom % 20 == 0));
            step(1, x, y, noise && ($urandom % 40 == 0), noise && ($urandom % 40 == 0));
        end
    endtask

    task automatic frame_end();
        for (int x = WX + 223; x <= WX + 255; x++) step(1, x, WY + 255, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        for (int i = 0; i < 2048; i++) begin
            mem0[i] = $urandom;
            mem1[i] = $urandom;
        end
        repeat (4) @(negedge clk);
        // R1
        check(pix_rgb == BLACK, "R1 pix_rgb", 32'(pix_rgb), 32'(BLACK));
        check(buf_sel == 1'b0, "R1 buf_sel", 32'(buf_sel), 0);
        check(upd_start == 1'b0, "R1 upd_start", 32'(upd_start), 0);
        check(rd_en == 1'b0, "R1 rd_en", 32'(rd_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pix_rgb == BLACK && !upd_start, "R1 after release", 32'(pix_rgb), 32'(BLACK));

        // directed: first and last rows, outside pixels
        scan_row(WY, 0, 0);
        scan_row(WY + 255, 0, 0);
        step(1, 0, 0, 0, 0);                         // R5
        step(1, WX + 10, WY - 1, 0, 0);              // R5 row above
        step(1, WX + 10, WY + 256, 0, 0);            // R5 row below
        step(0, WX + 5, WY + 5, 0, 0);               // R6
        // R10: frame end while counting
        frame_end();
        // R9: ticks short of the limit, then the last one
        for (int i = 0; i < TK - 1; i++) step(0, 0, 0, 1, 0);
        frame_end();
        step(0, 0, 0, 0, 1);                         // R7 done ignored in COUNT
        step(0, 0, 0, 1, 0);                         // reaches ARMED
        step(0, 0, 0, 0, 1);                         // R7 done ignored in ARMED
        frame_end();                                 // R8 start pulse
        for (int i = 0; i < 2 * TK; i++) step(0, 0, 0, 1, 0); // R9 ignored in UPDATE
        frame_end();                                 // R10 no start in UPDATE
        step(0, 0, 0, 0, 1);                         // R7 swap
        scan_row(WY + 17, 0, 0);                     // R7 reads other memory
        for (int i = 0; i < TK; i++) step(0, 0, 0, 1, 0);
        frame_end();
        step(0, 0, 0, 0, 1);                         // swap back

        // constrained random
        for (int it = 0; it < 40; it++) begin
            case ($urandom % 4)
                0, 1: scan_row(WY + ($urandom % 256), 1, 1);
                2: frame_end();
                default: for (int k = 0; k < 8; k++)
                    step($urandom % 2, $urandom % 1024, $urandom % 1024,
                         $urandom % 2, $urandom % 3 == 0);
            endcase
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule